// File: doc/BRIEF.md
# Buffered Flash Write Sequencer

This block sits on the host side of a parallel NOR-style flash and writes a run of words through the device's write buffer. The user supplies a start address, a total word count and a one-cycle start pulse, then streams data words over a valid/ready handshake. The sequencer breaks the run into buffer-sized chunks. For each chunk it obtains the write buffer, states the chunk length, fills the buffer from the stream, confirms the operation and waits for the device to finish.

No chunk ever crosses a 32-word aligned boundary. A run that begins partway into a boundary window first gets a short chunk that ends at the next boundary. The chunks after it are full aligned buffers, and the last chunk holds whatever remains. Status reads steer every step: buffer availability, completion, and the failure and lock flags. Any error abandons the chunks not yet written. The run always ends with a status clear and a return to array-read mode, followed by a one-cycle done pulse that carries a two-bit result code.

The flash side is a simple synchronous strobe interface. A write strobe lasts one cycle and carries an address and a data word. A read strobe asks for the status word, which the device returns on the read data input in the following cycle.

Top module: `bufwr_seq`

## Requirements
- R1: After reset the block is idle: write strobe, read strobe, `in_ready`, `busy` and `done` are all low, and the two strobes are never high together.
- R2: Each chunk opens with a write of command E8h at the chunk's first address, followed by a status read. While status bit 7 reads 0, the E8h write and the status read are repeated.
- R3: Once bit 7 reads 1, the chunk length minus one is written at the chunk's first address. The length is the smaller of the words still owed and the words left before the next 32-word aligned boundary, so the written value lies in 00h..1Fh and the chunk never crosses a boundary.
- R4: During the fill phase `in_ready` is high. Each accepted stream word (`in_valid` and `in_ready` both high) is written in that same cycle at consecutive addresses starting at the chunk's first address, for exactly length-plus-one... that is, exactly length words. `in_ready` is low in every other phase.
- R5: After the last data word, command D0h is written at the chunk's first address, and status is then read until bit 7 reads 1.
- R6: After each completion, command 50h (clear status) is written. If words remain and no error occurred, the next chunk starts at the address that follows the last word written.
- R7: On completion, status bit 1 set gives result code 2 (lock) and bit 4 set with bit 1 clear gives result code 1 (program failure). Either error abandons all remaining chunks.
- R8: If `POLL_LIMIT` consecutive status reads within one wait (availability or completion) return bit 7 = 0, the run ends with result code 3 (timeout).
- R9: Every run ends with a write of FFh followed in the next cycle by `done` high for exactly one cycle. `done_err` holds the result code (0 for success).
- R10: A start pulse while `busy` is high, or one with a total of zero, is ignored: it causes no flash access and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| start_addr | input | AW | First word address of the run |
| word_total | input | LW | Number of words in the run (1..MAX_WORDS) |
| in_valid | input | 1 | Stream word present |
| in_data | input | DW | Stream word |
| in_ready | output | 1 | Sequencer takes the stream word this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| done_err | output | 2 | Result code: 0 ok, 1 program failure, 2 lock, 3 timeout |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data or command |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash status read strobe |
| fl_rdata | input | DW | Status word, valid the cycle after `fl_re` |

## Verification
A wrong chunk base or length shows at the flash port within the same run. The count write lands at the wrong address or carries the wrong value, and the data then lands outside the intended window, so the model's chunk log and memory image disagree with the expected split as soon as the run ends. A wrong result or a missed abort shows at `done_err`, and in the number of chunks the device saw, by the done pulse that ends the run. A stuck poll counter shows as a missing or premature timeout code within about two cycles per allowed poll. A broken handshake shows within one word as a missing, repeated or shifted data word in memory.

// File: rtl/bws_pkg.sv
package bws_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_SETUP,
      S_AV_RD,
      S_AV_WT,
      S_COUNT,
      S_FILL,
      S_CONF,
      S_ST_RD,
      S_ST_WT,
      S_CLR,
      S_ARR,
      S_DONE
   } bws_state_e;

   typedef enum logic [1:0] {
      E_NONE = 2'd0,
      E_PROG = 2'd1,
      E_LOCK = 2'd2,
      E_TMO  = 2'd3
   } bws_err_e;

   localparam logic [7:0] CMD_SETUP = 8'hE8;
   localparam logic [7:0] CMD_CONF  = 8'hD0;
   localparam logic [7:0] CMD_CLR   = 8'h50;
   localparam logic [7:0] CMD_ARR   = 8'hFF;

   localparam int RDY_BIT  = 7;
   localparam int FAIL_BIT = 4;
   localparam int LOCK_BIT = 1;

endpackage

// File: rtl/bws_chunk_calc.sv
module bws_chunk_calc #(
   parameter int AW        = 16,
   parameter int LW        = 11,
   parameter int BUF_WORDS = 32,
   localparam int BW       = $clog2(BUF_WORDS)
) (
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] remain,
   output logic [BW:0]   len,
   output logic [BW-1:0] len_m1
);

   localparam logic [BW:0] FULL = (BW+1)'(BUF_WORDS);

   logic [BW:0]   room;
   logic [LW-1:0] room_w;

   assign room   = FULL - {1'b0, base[BW-1:0]};
   assign room_w = LW'(room);
   assign len    = (remain < room_w) ? remain[BW:0] : room;
   assign len_m1 = BW'(len - (BW+1)'(1));

endmodule

// File: rtl/bws_poll_timer.sv
module bws_poll_timer #(
   parameter int LIMIT = 64,
   localparam int CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic last
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (tick && !last) begin
         cnt <= cnt + CW'(1);
      end
   end

   assign last = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/bws_stat_decode.sv
module bws_stat_decode
   import bws_pkg::*;
#(
   parameter int DW         = 16,
   parameter bit LOCK_CHECK = 1'b1
) (
   input  logic [DW-1:0] status,
   output logic          ready,
   output bws_err_e      err
);

   logic fail_f, lock_f;
   logic unused_bits;

   assign ready       = status[RDY_BIT];
   assign fail_f      = status[FAIL_BIT];
   assign lock_f      = status[LOCK_BIT];
   assign unused_bits = ^status;

   generate
      if (LOCK_CHECK) begin : g_lock_split
         always_comb begin
            if (lock_f)      err = E_LOCK;
            else if (fail_f) err = E_PROG;
            else             err = E_NONE;
         end
      end else begin : g_lock_merged
         always_comb begin
            if (lock_f || fail_f) err = E_PROG;
            else                  err = E_NONE;
         end
      end
   endgenerate

endmodule

// File: rtl/bufwr_seq.sv
module bufwr_seq
   import bws_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int BUF_WORDS  = 32,
   parameter int MAX_WORDS  = 1024,
   parameter int POLL_LIMIT = 64,
   parameter bit LOCK_CHECK = 1'b1,
   localparam int LW        = $clog2(MAX_WORDS + 1),
   localparam int BW        = $clog2(BUF_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [LW-1:0] word_total,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          in_ready,
   output logic          busy,
   output logic          done,
   output logic [1:0]    done_err,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_wdata,
   output logic          fl_we,
   output logic          fl_re,
   input  logic [DW-1:0] fl_rdata
);

   generate
      if (BUF_WORDS < 2 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_bad_buf
         $error("BUF_WORDS must be a power of two of at least 2");
      end
      if (MAX_WORDS < BUF_WORDS) begin : g_bad_max
         $error("MAX_WORDS must be at least BUF_WORDS");
      end
      if (DW < 8) begin : g_bad_dw
         $error("DW must hold an 8-bit command");
      end
      if (AW <= BW) begin : g_bad_aw
         $error("AW must exceed the buffer offset width");
      end
      if (POLL_LIMIT < 2) begin : g_bad_poll
         $error("POLL_LIMIT must be at least 2");
      end
   endgenerate

   bws_state_e    state;
   bws_err_e      err_q;
   bws_err_e      st_err;
   logic [AW-1:0] chunk_base;
   logic [AW-1:0] cur_addr;
   logic [LW-1:0] remain;
   logic [BW-1:0] fill_left;
   logic [BW:0]   len;
   logic [BW-1:0] len_m1;
   logic          st_ready;
   logic          poll_last;
   logic          poll_clear;
   logic          poll_tick;

   bws_chunk_calc #(
      .AW(AW), .LW(LW), .BUF_WORDS(BUF_WORDS)
   ) u_chunk (
      .base   (chunk_base),
      .remain (remain),
      .len    (len),
      .len_m1 (len_m1)
   );

   bws_stat_decode #(
      .DW(DW), .LOCK_CHECK(LOCK_CHECK)
   ) u_dec (
      .status (fl_rdata),
      .ready  (st_ready),
      .err    (st_err)
   );

   assign poll_clear = (state == S_IDLE) || (state == S_COUNT) || (state == S_CLR);
   assign poll_tick  = ((state == S_AV_WT) || (state == S_ST_WT)) && !st_ready;

   bws_poll_timer #(
      .LIMIT(POLL_LIMIT)
   ) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (poll_clear),
      .tick  (poll_tick),
      .last  (poll_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         err_q      <= E_NONE;
         chunk_base <= '0;
         cur_addr   <= '0;
         remain     <= '0;
         fill_left  <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start && (word_total != '0)) begin
                  chunk_base <= start_addr;
                  cur_addr   <= start_addr;
                  remain     <= word_total;
                  err_q      <= E_NONE;
                  state      <= S_SETUP;
               end
            end
            S_SETUP: state <= S_AV_RD;
            S_AV_RD: state <= S_AV_WT;
            S_AV_WT: begin
               if (st_ready) begin
                  state <= S_COUNT;
               end else if (poll_last) begin
                  err_q <= E_TMO;
                  state <= S_CLR;
               end else begin
                  state <= S_SETUP;
               end
            end
            S_COUNT: begin
               fill_left <= len_m1;
               remain    <= remain - LW'(len);
               state     <= S_FILL;
            end
            S_FILL: begin
               if (in_valid) begin
                  cur_addr <= cur_addr + AW'(1);
                  if (fill_left == '0) state <= S_CONF;
                  else                 fill_left <= fill_left - BW'(1);
               end
            end
            S_CONF:  state <= S_ST_RD;
            S_ST_RD: state <= S_ST_WT;
            S_ST_WT: begin
               if (st_ready) begin
                  err_q <= st_err;
                  state <= S_CLR;
               end else if (poll_last) begin
                  err_q <= E_TMO;
                  state <= S_CLR;
               end else begin
                  state <= S_ST_RD;
               end
            end
            S_CLR: begin
               if (err_q != E_NONE || remain == '0) begin
                  state <= S_ARR;
               end else begin
                  chunk_base <= cur_addr;
                  state      <= S_SETUP;
               end
            end
            S_ARR:   state <= S_DONE;
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      fl_we    = 1'b0;
      fl_re    = 1'b0;
      fl_addr  = chunk_base;
      fl_wdata = '0;
      in_ready = 1'b0;
      case (state)
         S_SETUP: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(CMD_SETUP);
         end
         S_AV_RD, S_ST_RD: fl_re = 1'b1;
         S_COUNT: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(len_m1);
         end
         S_FILL: begin
            in_ready = 1'b1;
            fl_we    = in_valid;
            fl_wdata = in_data;
            fl_addr  = cur_addr;
         end
         S_CONF: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(CMD_CONF);
         end
         S_CLR: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(CMD_CLR);
         end
         S_ARR: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(CMD_ARR);
         end
         default: ;
      endcase
   end

   assign busy     = (state != S_IDLE);
   assign done     = (state == S_DONE);
   assign done_err = err_q;

endmodule

// File: rtl/bws_checker.sv
module bws_checker
   import bws_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int BUF_WORDS = 32,
   localparam int BW       = $clog2(BUF_WORDS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          in_valid,
   input logic          in_ready,
   input logic [DW-1:0] in_data,
   input logic          fl_we,
   input logic          fl_re,
   input logic [AW-1:0] fl_addr,
   input logic [DW-1:0] fl_wdata,
   input bws_state_e    st
);

   localparam logic [BW:0] FULL = (BW+1)'(BUF_WORDS);

   p_excl_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   p_fill_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (fl_we && fl_wdata == in_data));

   p_ready_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   p_count_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_COUNT) |->
         ((({1'b0, fl_addr[BW-1:0]} + {1'b0, fl_wdata[BW-1:0]}) < FULL) &&
          ((fl_wdata >> BW) == '0)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_array_before_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(fl_we && fl_wdata[7:0] == CMD_ARR));

   p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

bind bufwr_seq bws_checker #(
   .AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS)
) u_bws_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_data  (in_data),
   .fl_we    (fl_we),
   .fl_re    (fl_re),
   .fl_addr  (fl_addr),
   .fl_wdata (fl_wdata),
   .st       (state)
);

// File: tb/tb_bufwr_seq.sv
`timescale 1ns/1ps
module tb_bufwr_seq;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int LW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [LW-1:0] word_total = '0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready, busy, done;
   logic [1:0]    done_err;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_wdata;
   logic          fl_we, fl_re;
   logic [DW-1:0] fl_rdata = '0;

   bufwr_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_total(word_total), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .busy(busy), .done(done), .done_err(done_err),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
      .fl_rdata(fl_rdata)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // ---------------- flash model ----------------
   logic [15:0] mem [0:511];
   logic [15:0] pa [0:31];
   logic [15:0] pd [0:31];
   int pn, phase, exp_left;
   int avail_wait = 0, avail_left = 0;
   int prog_wait = 0, prog_left = 0;
   bit hang = 0, f_lock = 0, f_fail = 0, st_lock = 0, st_fail = 0;
   int n_setup, n_conf, n_clr, n_ff, n_seqerr, n_ch;
   int ch_base [0:7];
   int ch_len  [0:7];

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = 16'hFFFF;
      phase = 0; pn = 0; exp_left = 0;
   end

   always @(posedge clk) begin
      cycles++;
      if (fl_re) begin
         bit rdy;
         rdy = 1'b1;
         if (phase == 1) begin
            rdy = (avail_left == 0);
            if (!rdy) avail_left--;
         end else if (phase == 4) begin
            if (hang) rdy = 1'b0;
            else if (prog_left > 0) begin rdy = 1'b0; prog_left--; end
         end
         fl_rdata <= {8'h00, rdy, 2'b00, (rdy ? st_fail : 1'b0), 2'b00,
                      (rdy ? st_lock : 1'b0), 1'b0};
      end
      if (fl_we) begin
         logic [7:0] cmd;
         cmd = fl_wdata[7:0];
         case (phase)
            0: begin
               if (cmd == 8'hE8) begin phase = 1; avail_left = avail_wait; n_setup++; end
               else if (cmd == 8'h50) begin st_fail = 0; st_lock = 0; n_clr++; end
               else if (cmd == 8'hFF) n_ff++;
               else n_seqerr++;
            end
            1: begin
               if (cmd == 8'hE8) n_setup++;
               else if (cmd == 8'h50) begin st_fail = 0; st_lock = 0; n_clr++; phase = 0; end
               else if (cmd == 8'hFF) begin n_ff++; phase = 0; end
               else begin
                  if (avail_left != 0 || fl_wdata > 16'd31) n_seqerr++;
                  if (n_ch < 8) begin
                     ch_base[n_ch] = int'(fl_addr);
                     ch_len[n_ch]  = int'(fl_wdata) + 1;
                  end
                  n_ch++;
                  exp_left = int'(fl_wdata) + 1;
                  pn = 0;
                  phase = 2;
               end
            end
            2: begin
               if (pn < 32) begin pa[pn] = fl_addr; pd[pn] = fl_wdata; end
               pn++;
               exp_left--;
               if (exp_left == 0) phase = 3;
            end
            3: begin
               if (cmd == 8'hD0) begin
                  n_conf++;
                  phase = 4;
                  prog_left = prog_wait;
                  st_lock = f_lock;
                  st_fail = f_fail | f_lock;
                  if (!f_lock && !f_fail)
                     for (int k = 0; k < pn && k < 32; k++) mem[pa[k][8:0]] = pd[k];
               end else n_seqerr++;
            end
            default: begin
               if (cmd == 8'h50) begin st_fail = 0; st_lock = 0; n_clr++; phase = 0; end
               else if (cmd == 8'hFF) begin n_ff++; phase = 0; end
               else n_seqerr++;
            end
         endcase
      end
   end

   // ---------------- stream source ----------------
   logic [15:0] src [0:63];
   int  feed_n = 0, feed_idx = 0;
   bit  feed_on = 0, feed_gap = 0, took = 0;
   int  done_cnt = 0;
   logic [1:0] last_err = 2'd0;

   always @(posedge clk) begin
      took <= in_valid && in_ready;
      if (done) begin
         done_cnt <= done_cnt + 1;
         last_err <= done_err;
      end
   end

   always @(negedge clk) begin
      if (feed_on) begin
         if (took) feed_idx++;
         if (feed_idx < feed_n) begin
            in_valid = !(feed_gap && (cycles % 3 == 0));
            in_data  = src[feed_idx];
         end else begin
            in_valid = 1'b0;
         end
      end else begin
         in_valid = 1'b0;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_model();
      n_setup = 0; n_conf = 0; n_clr = 0; n_ff = 0; n_seqerr = 0; n_ch = 0;
      phase = 0;
   endtask

   task automatic run_job(input int base, input int n, input bit gap, input int tag,
                          input bit poke_busy);
      int d0;
      for (int i = 0; i < 64; i++) src[i] = 16'(16'h1000 * tag + 16'h0101 * i + 7);
      clear_model();
      feed_n = n; feed_idx = 0; feed_gap = gap; feed_on = 1;
      d0 = done_cnt;
      @(negedge clk);
      start = 1'b1; start_addr = AW'(base); word_total = LW'(n);
      @(negedge clk);
      start = 1'b0;
      if (poke_busy) begin
         repeat (6) @(negedge clk);
         start = 1'b1; start_addr = 16'h0180; word_total = 11'd5;
         @(negedge clk);
         start = 1'b0;
      end
      for (int w = 0; w < 5000 && done_cnt == d0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
      feed_on = 0;
      chk(done_cnt == d0 + 1, "R9", "done pulse count", done_cnt - d0, 1);
   endtask

   task automatic chk_mem(input string req, input int base, input int n, input bit written);
      bit ok;
      int bad_a, bad_v, bad_e;
      ok = 1; bad_a = 0; bad_v = 0; bad_e = 0;
      for (int i = 0; i < n; i++) begin
         logic [15:0] e;
         e = written ? src[i] : 16'hFFFF;
         if (ok && mem[(base + i) & 511] !== e) begin
            ok = 0; bad_a = base + i; bad_v = mem[(base + i) & 511]; bad_e = e;
         end
      end
      chk(ok, req, $sformatf("memory at %0h", bad_a), bad_v, bad_e);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk(!fl_we && !fl_re, "R1", "strobes in reset", {fl_we, fl_re}, 0);
      chk(!in_ready && !busy && !done, "R1", "ready/busy/done in reset",
          {in_ready, busy, done}, 0);
   endtask

   task automatic t_aligned();
      avail_wait = 0; prog_wait = 2;
      run_job(16'h040, 32, 0, 1, 0);
      chk(last_err == 2'd0, "R9", "aligned result", last_err, 0);
      chk(n_ch == 1 && ch_base[0] == 16'h40 && ch_len[0] == 32, "R3", "aligned chunk",
          ch_len[0], 32);
      chk_mem("R4", 16'h040, 32, 1);
      chk(n_conf == 1 && n_clr == 1 && n_ff == 1 && n_seqerr == 0, "R5",
          "confirm/clear/array counts", n_conf * 256 + n_clr * 16 + n_ff, 16'h111);
   endtask

   task automatic t_split();
      avail_wait = 0; prog_wait = 1;
      run_job(16'h11C, 40, 1, 2, 0);
      chk(last_err == 2'd0, "R6", "split result", last_err, 0);
      chk(n_ch == 3, "R6", "split chunk count", n_ch, 3);
      chk(ch_base[0] == 16'h11C && ch_len[0] == 4, "R3", "first chunk ends on boundary",
          ch_len[0], 4);
      chk(ch_base[1] == 16'h120 && ch_len[1] == 32, "R3", "middle chunk aligned full",
          ch_base[1], 16'h120);
      chk(ch_base[2] == 16'h140 && ch_len[2] == 4, "R3", "tail chunk", ch_len[2], 4);
      chk(n_clr == 3 && n_seqerr == 0, "R6", "clear per chunk", n_clr, 3);
      chk_mem("R4", 16'h11C, 40, 1);
   endtask

   task automatic t_avail_retry();
      avail_wait = 3; prog_wait = 0;
      run_job(16'h080, 5, 0, 3, 0);
      chk(n_setup == 4, "R2", "setup reissued while buffer busy", n_setup, 4);
      chk(last_err == 2'd0 && n_seqerr == 0, "R2", "retry result", last_err, 0);
      chk_mem("R2", 16'h080, 5, 1);
      avail_wait = 0;
   endtask

   task automatic t_lock();
      f_lock = 1; prog_wait = 0;
      run_job(16'h1A0, 10, 0, 4, 0);
      chk(last_err == 2'd2, "R7", "lock result code", last_err, 2);
      chk_mem("R7", 16'h1A0, 10, 0);
      chk(n_clr == 1 && n_ff == 1, "R9", "lock ends with clear and array", n_ff, 1);
      f_lock = 0;
   endtask

   task automatic t_fail();
      f_fail = 1; prog_wait = 5;
      run_job(16'h1DE, 6, 0, 5, 0);
      chk(last_err == 2'd1, "R7", "program failure code", last_err, 1);
      chk(n_ch == 1 && ch_len[0] == 2, "R7", "remaining chunks abandoned", n_ch, 1);
      chk_mem("R7", 16'h1DE, 6, 0);
      f_fail = 0; prog_wait = 0;
   endtask

   task automatic t_timeout();
      hang = 1;
      run_job(16'h000, 3, 0, 6, 0);
      chk(last_err == 2'd3, "R8", "timeout code", last_err, 3);
      chk(n_ff == 1, "R8", "array command after timeout", n_ff, 1);
      hang = 0;
   endtask

   task automatic t_busy_ignore();
      prog_wait = 20;
      run_job(16'h100, 4, 0, 7, 1);
      chk(n_ch == 1 && ch_base[0] == 16'h100, "R10", "start while busy ignored",
          n_ch, 1);
      chk(last_err == 2'd0 && !busy, "R10", "busy run finishes idle", busy, 0);
      prog_wait = 0;
   endtask

   task automatic t_zero();
      int d0;
      bit act;
      clear_model();
      d0 = done_cnt; act = 0;
      @(negedge clk);
      start = 1'b1; start_addr = 16'h0010; word_total = '0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (busy || fl_we || fl_re) act = 1;
         @(negedge clk);
      end
      chk(!act && done_cnt == d0, "R10", "zero total ignored", act, 0);
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      join_none
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_aligned();
      t_split();
      t_avail_retry();
      t_lock();
      t_fail();
      t_timeout();
      t_busy_ignore();
      t_zero();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule